// File: doc/BRIEF.md
# Microwire Serial EEPROM Responder

This block answers a host that bit-bangs a three-wire serial EEPROM by writing a control word. The control word carries a serial clock, a chip select, a data-in bit and a few handshake bits; reading it back returns the same bits plus a data-out bit that the responder drives. The responder holds 64 sixteen-bit words. A host selects the device, clocks in a start bit, a two-bit opcode and a six-bit word address, and then keeps toggling the clock to receive data one bit at a time, most significant bit first.

Only a change of the clock bit between two control writes is treated as a clock event. Rising edges shift data in. Falling edges advance one running output position that runs across word boundaries, so a host can keep clocking and receive consecutive words. The contents are filled through a separate load port. A seal pulse writes the last word so that the sum of all words is a fixed constant.

Top module: `srom_responder`

## Requirements
- R1: After reset the control read value is 0x188. Bit 8 (present) and bit 7 (grant) are set. Bit 3 (data-out) is 1. All stored pin bits are 0.
- R2: The control read value echoes the last written clock (bit 0), select (bit 1), data-in (bit 2), write-enable field (bits 5:4) and request (bit 6). Bits 8 and 7 always read 1. Bit 3 reads data-out, and any value written to bits 3, 7 and 8 is ignored.
- R3: A control write that leaves the clock bit unchanged causes no protocol event, even when it changes select or data-in.
- R4: A rising clock with select low clears the command shifter, the input count, the output position and the read state, so data-out returns to 1.
- R5: With select high, each rising clock shifts data-in into the shifter LSB. On the ninth rising clock, if no read is active, the output position loads (address × 16) − 1. Each falling clock adds one to the output position, so after the next falling clock data-out shows bit 15 of the addressed word.
- R6: Data-out is bit (15 − pos[3:0]) of word pos[9:4]. Continued clocking therefore streams the next word, and word 63 is followed by word 0.
- R7: A read starts only when command bits 8:6 equal binary 110 (start bit 1, opcode 10). Any other command leaves data-out at 1.
- R8: Once a read is active, further rising clocks do not restart the command, whatever data-in carries.
- R9: A seal pulse writes word 63 so that words 0 to 63 sum to 0xBABA modulo 2^16. If the load port writes word 63 in the same cycle, the seal wins.
- R10: A load-port write stores the data at the given word address on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word written by the host |
| ctl_rdata | output | 9 | Control word read value, including data-out |
| ld_we | input | 1 | Contents load strobe |
| ld_addr | input | 6 | Word address for a load |
| ld_data | input | 16 | Word value for a load |
| ld_seal | input | 1 | Computes and writes the checksum word |

## Verification
Read commands are issued for low, middle and top addresses. Comparing the words streamed back shows whether the start position and the MSB-first order are right. Streams run past a word boundary and past word 63, which separates a per-word counter from the single running position. Commands with wrong opcodes, select dropped with the clock held, select low on a rising clock, and data-in toggled during a read each target one protocol rule. The top word is read after a seal, which ties the checksum arithmetic to the serial path.

// File: rtl/srr_pkg.sv
package srr_pkg;
  // control word bit positions (host software decodes these)
  localparam int CTL_W   = 9;
  localparam int CB_SK   = 0;
  localparam int CB_CS   = 1;
  localparam int CB_DI   = 2;
  localparam int CB_DO   = 3;
  localparam int CB_WEN  = 4;  // two bits, 5:4
  localparam int CB_REQ  = 6;
  localparam int CB_GNT  = 7;
  localparam int CB_PRES = 8;

  localparam int       OP_W    = 3;
  localparam logic [2:0] OP_READ = 3'b110;

  typedef struct packed {
    logic       req;
    logic [1:0] wen;
    logic       di;
    logic       cs;
    logic       sk;
  } pins_t;
endpackage

// File: rtl/srr_pins.sv
module srr_pins
  import srr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output pins_t            pins_q,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             cs_now,
  output logic             di_now
);
  pins_t pins_d;

  always_comb begin
    pins_d.sk  = wdata[CB_SK];
    pins_d.cs  = wdata[CB_CS];
    pins_d.di  = wdata[CB_DI];
    pins_d.wen = wdata[CB_WEN +: 2];
    pins_d.req = wdata[CB_REQ];
  end

  assign rise_evt = we &&  pins_d.sk && !pins_q.sk;
  assign fall_evt = we && !pins_d.sk &&  pins_q.sk;
  assign cs_now   = pins_d.cs;
  assign di_now   = pins_d.di;

  always_ff @(posedge clk) begin
    if (!rst_n)  pins_q <= '0;
    else if (we) pins_q <= pins_d;
  end

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(pins_q)); // R2
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt)); // R3
endmodule

// File: rtl/srr_proto.sv
module srr_proto
  import srr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rise_evt,
  input  logic                       fall_evt,
  input  logic                       cs_now,
  input  logic                       di_now,
  output logic                       reading,
  output logic [ADDR_W+$clog2(WORD_W)-1:0] out_pos
);
  localparam int SEL_W = $clog2(WORD_W);
  localparam int POS_W = ADDR_W + SEL_W;
  localparam int CMD_W = OP_W + ADDR_W;
  localparam int CNT_W = $clog2(CMD_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CMD_W + 1);

  function automatic logic [POS_W-1:0] start_pos(input logic [ADDR_W-1:0] a);
    return {a, {SEL_W{1'b0}}} - POS_W'(1);
  endfunction

  logic [CMD_W-1:0] shift_q, shift_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             proto_clear, cmd_done, op_is_read;

  assign shift_nxt   = {shift_q[CMD_W-2:0], di_now};
  assign cnt_inc     = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
  assign proto_clear = rise_evt && !cs_now;
  assign cmd_done    = rise_evt && cs_now && !reading && (cnt_inc == CNT_W'(CMD_W));
  assign op_is_read  = (shift_nxt[CMD_W-1 -: OP_W] == OP_READ);

  always_ff @(posedge clk) begin
    if (!rst_n || proto_clear) begin
      shift_q <= '0;
      cnt_q   <= '0;
      out_pos <= '0;
      reading <= 1'b0;
    end else if (rise_evt) begin
      shift_q <= shift_nxt;
      cnt_q   <= cnt_inc;
      if (cmd_done) begin
        out_pos <= start_pos(shift_nxt[ADDR_W-1:0]);
        reading <= op_is_read;
      end
    end else if (fall_evt) begin
      out_pos <= out_pos + POS_W'(1);
    end
  end

  AST_SELECT_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    proto_clear |=> (!reading && out_pos == '0 && cnt_q == '0)); // R4
  AST_FALL_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> out_pos == $past(out_pos) + POS_W'(1)); // R5
  AST_LOAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> out_pos[SEL_W-1:0] == {SEL_W{1'b1}}); // R5
  AST_NO_EVENT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_evt && !fall_evt) |=> ($stable(reading) && $stable(out_pos) && $stable(cnt_q))); // R3
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !proto_clear) |=> reading); // R8
endmodule

// File: rtl/srr_store.sv
module srr_store #(
  parameter int          ADDR_W = 6,
  parameter int          WORD_W = 16,
  parameter logic [15:0] CKSUM  = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              seal,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] part_sum, seal_word, total_sum;

  always_comb begin
    part_sum = '0;
    for (int i = 0; i < DEPTH - 1; i++) part_sum = part_sum + mem_q[i];
    total_sum = part_sum + mem_q[DEPTH-1];
  end
  assign seal_word = WORD_W'(CKSUM) - part_sum;
  assign rd_word   = mem_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (ld_we) mem_q[ld_addr] <= ld_data;
      if (seal)  mem_q[LAST]    <= seal_word;
    end
  end

  AST_SEAL_BALANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (seal && !ld_we) |=> total_sum == WORD_W'(CKSUM)); // R9
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && !(seal && ld_addr == LAST)) |=> mem_q[$past(ld_addr)] == $past(ld_data)); // R10
endmodule

// File: rtl/srom_responder.sv
module srom_responder
  import srr_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter int          WORD_W = 16,
  parameter logic [15:0] CKSUM  = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_seal
);
  localparam int SEL_W = $clog2(WORD_W);
  localparam int POS_W = ADDR_W + SEL_W;

  function automatic logic pick_bit(input logic [WORD_W-1:0] w, input logic [SEL_W-1:0] s);
    return w[SEL_W'(WORD_W - 1) - s];
  endfunction

  pins_t             pins_q;
  logic              rise_evt, fall_evt, cs_now, di_now, reading, do_bit;
  logic [POS_W-1:0]  out_pos;
  logic [WORD_W-1:0] cur_word;

  srr_pins u_pins (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .pins_q(pins_q), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .cs_now(cs_now), .di_now(di_now)
  );

  srr_proto #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .cs_now(cs_now), .di_now(di_now), .reading(reading), .out_pos(out_pos)
  );

  srr_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CKSUM(CKSUM)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .seal(ld_seal), .rd_idx(out_pos[POS_W-1:SEL_W]),
    .rd_word(cur_word)
  );

  assign do_bit = reading ? pick_bit(cur_word, out_pos[SEL_W-1:0]) : 1'b1;

  always_comb begin
    ctl_rdata              = '0;
    ctl_rdata[CB_SK]       = pins_q.sk;
    ctl_rdata[CB_CS]       = pins_q.cs;
    ctl_rdata[CB_DI]       = pins_q.di;
    ctl_rdata[CB_DO]       = do_bit;
    ctl_rdata[CB_WEN +: 2] = pins_q.wen;
    ctl_rdata[CB_REQ]      = pins_q.req;
    ctl_rdata[CB_GNT]      = 1'b1;
    ctl_rdata[CB_PRES]     = 1'b1;
  end

  AST_PINS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[CB_SK] == $past(ctl_wdata[CB_SK]) &&
                ctl_rdata[CB_CS] == $past(ctl_wdata[CB_CS]) &&
                ctl_rdata[CB_DI] == $past(ctl_wdata[CB_DI]))); // R2
endmodule

// File: tb/srom_responder_tb_top.sv
`timescale 1ns/1ps
module srom_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [8:0]  ctl_wdata = '0;
  logic [8:0]  ctl_rdata;
  logic        ld_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        ld_seal = 1'b0;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  srom_responder dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .ld_seal(ld_seal)
  );

  // stimulus table: command bits 8:6 and word address
  localparam int NV = 7;
  localparam logic [2:0] TBL_OP [NV] = '{3'b110, 3'b110, 3'b101, 3'b110, 3'b111, 3'b110, 3'b110};
  localparam logic [5:0] TBL_AD [NV] = '{6'd0, 6'd1, 6'd17, 6'd42, 6'd5, 6'd62, 6'd63};

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h0B1D) ^ 16'h5A3C);
  endfunction

  function automatic logic [15:0] seal_val();
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) s = s + pat(i);
    return 16'hBABA - s;
  endfunction

  function automatic logic [15:0] expect_word(input logic [2:0] op, input logic [5:0] a);
    if (op != 3'b110) return 16'hFFFF;
    if (a == 6'd63) return seal_val();
    return pat(int'(a));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [8:0] d);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr(input logic sk, input logic cs, input logic di);
    wr_raw({6'b0, di, cs, sk});
  endtask

  task automatic deselect();
    wr(1'b1, 1'b0, 1'b0);
    wr(1'b0, 1'b0, 1'b0);
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [5:0] a);
    logic [8:0] c = {op, a};
    wr(1'b0, 1'b1, 1'b0);
    for (int i = 8; i >= 0; i--) begin
      wr(1'b0, 1'b1, c[i]);
      wr(1'b1, 1'b1, c[i]);
      wr(1'b0, 1'b1, c[i]);
    end
  endtask

  task automatic grab(input logic di, output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      w[i] = ctl_rdata[3];
      wr(1'b1, 1'b1, di);
      wr(1'b0, 1'b1, di);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", 16'(ctl_rdata), 16'h0188);

    // R2: echo of pin bits, fixed status bits, ignored bits
    wr_raw(9'h076);
    chk("R2 echo", 16'(ctl_rdata), 16'h01FE);
    wr_raw(9'h188);
    chk("R2 ignored bits", 16'(ctl_rdata), 16'h0188);

    // R10: fill contents, R9: seal word 63
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 6'(i); ld_data = (i == 63) ? 16'hFFFF : pat(i);
    end
    @(negedge clk);
    ld_we = 1'b0; ld_seal = 1'b1;
    @(negedge clk);
    ld_seal = 1'b0;

    // table walk: R5 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      deselect();
      send_cmd(TBL_OP[v], TBL_AD[v]);
      grab(1'b0, w);
      chk($sformatf("R5 R7 R9 R10 vector %0d", v), w, expect_word(TBL_OP[v], TBL_AD[v]));
    end

    // R6: stream continues into next word, and 63 wraps to 0
    deselect();
    send_cmd(3'b110, 6'd42);
    grab(1'b0, w);
    grab(1'b0, w);
    chk("R6 next word", w, pat(43));
    deselect();
    send_cmd(3'b110, 6'd63);
    grab(1'b0, w);
    chk("R6 top word", w, seal_val());
    grab(1'b0, w);
    chk("R6 wrap to 0", w, pat(0));

    // R8: data-in ones during a read do not restart it
    deselect();
    send_cmd(3'b110, 6'd17);
    grab(1'b1, w);
    chk("R8 first", w, pat(17));
    grab(1'b1, w);
    chk("R8 second", w, pat(18));

    // R3: select low and data-in change with the clock held
    deselect();
    send_cmd(3'b110, 6'd5);
    wr(1'b0, 1'b0, 1'b1);
    chk("R3 bit held", 16'(ctl_rdata[3]), 16'(pat(5)[15]));
    wr(1'b0, 1'b1, 1'b0);
    grab(1'b0, w);
    chk("R3 word intact", w, pat(5));

    // R4: rising clock with select low ends the read
    deselect();
    send_cmd(3'b110, 6'd9);
    wr(1'b1, 1'b0, 1'b0);
    chk("R4 after rise", 16'(ctl_rdata[3]), 16'h0001);
    wr(1'b0, 1'b0, 1'b0);
    chk("R4 after fall", 16'(ctl_rdata[3]), 16'h0001);
    send_cmd(3'b110, 6'd9);
    grab(1'b0, w);
    chk("R4 recovery", w, pat(9));

    // R9: same-cycle load of word 63 loses to seal
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 6'd63; ld_data = 16'h1234; ld_seal = 1'b1;
    @(negedge clk);
    ld_we = 1'b0; ld_seal = 1'b0;
    deselect();
    send_cmd(3'b110, 6'd63);
    grab(1'b0, w);
    chk("R9 seal priority", w, seal_val());

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule